// File: doc/BRIEF.md
# External Trigger Timestamp Capture Unit

This block records the value of a free-running 64-bit time counter whenever a pulse arrives on one of two external trigger pins. Each trigger pin passes through a two-flop synchroniser and an edge detector. A per-channel control bit selects whether the rising or the falling edge is the active one. On every active edge the counter value is pushed into that channel's own 16-entry timestamp FIFO.

Software drains a channel through a small register interface. It polls a per-channel valid bit in a status register. For each entry it reads the low 32-bit word and then the high 32-bit word, and the read of the high word removes the entry. Each channel sets three event flags: one on a capture, one when the fill level reaches a shared threshold, and one when a capture is lost to a full FIFO. The flags are write-one-to-clear. Each flag has an enable bit, and the interrupt output is the OR of all enabled flags.

Register map (byte offsets on `reg_addr`):
- 0x00 control: polarity bits 8 (channel 0) and 9 (channel 1).
- 0x04 event flags.
- 0x08 event enables.
- 0x0C status.
- 0x10 threshold.
- 0x20 / 0x24: channel 0 low / high word.
- 0x28 / 0x2C: channel 1 low / high word.

Reads return data combinationally in the cycle `reg_rd` is high. Writes and pops take effect at that clock edge.

Top module: `trig_stamp_unit`

## Requirements
- R1: A trigger edge that is set up before rising clock edge N is seen by the detector after two synchroniser flops. The stored timestamp is the `time_cnt` value present at rising edge N+2.
- R2: Control bit 8 (channel 0) and bit 9 (channel 1) select the active edge: 0 means rising and 1 means falling. An edge in the opposite direction captures nothing, and changing the polarity bit while the pin is static captures nothing.
- R3: Each channel holds up to 16 timestamps and returns them in the order they were captured. Captures on one channel never appear on the other.
- R4: Status register 0x0C bit 24 (channel 0) and bit 25 (channel 1) read 1 exactly while that channel's FIFO holds at least one entry.
- R5: The low-word registers (0x20 / 0x28) return bits 31:0 of the head entry and leave the FIFO unchanged. The high-word registers (0x24 / 0x2C) return bits 63:32 of the head entry and remove it.
- R6: Reading either word of an empty channel returns 0 and changes no state.
- R7: A capture that arrives while the FIFO holds 16 entries is dropped and the stored entries are kept. The channel's overflow flag (bit 28 for channel 0, bit 29 for channel 1) is set.
- R8: The threshold register 0x10 resets to 7 and reads back what was written. A channel's threshold flag (bit 20 / 21) is set when a capture raises the fill count from below the threshold to equal or above it.
- R9: Every accepted or dropped capture sets the channel's capture flag (bit 24 / 25).
- R10: The flags in register 0x04 clear when a 1 is written to their bit positions. `irq` is high exactly when some flag is set and its enable bit at the same position in register 0x08 is set. Flags and enables reset to 0.
- R11: The control register resets to 0 and reads back its polarity bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| time_cnt | input | 64 | Free-running time counter value |
| trig_in | input | 2 | Asynchronous external trigger pins, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on a high-word address) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid combinationally while `reg_rd` is high |
| irq | output | 1 | OR of all enabled event flags |

## Verification
The bench moves the time counter on every cycle around each trigger. A synchroniser that is one flop too long or too short therefore stores a timestamp that is off by one. Each channel is driven to the opposite edge and to polarity flips on a static pin; a wrong edge detector would record extra entries and show a stray valid bit.

One channel is filled to 17 captures. This checks three things: the threshold flag must rise on the seventh capture and not the sixth, the overflow must not overwrite the oldest entry, and the drain must return all sixteen in order. A FIFO that popped on the low-word read would lose the second read of the same head. A FIFO that mishandled an empty read would return stale data or move its pointer. Flag clearing, threshold reprogramming and interrupt masking close the run.

// File: rtl/tsu_pkg.sv
`timescale 1ns/1ps
package tsu_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_FLAG   = 8'h04;
  localparam logic [7:0] OFS_EN     = 8'h08;
  localparam logic [7:0] OFS_STAT   = 8'h0C;
  localparam logic [7:0] OFS_THR    = 8'h10;
  localparam logic [7:0] OFS_STAMP0 = 8'h20;
  localparam int unsigned CH_STRIDE = 8;
  // bit bases inside registers (channel index is added)
  localparam int unsigned POL_BIT   = 8;
  localparam int unsigned THR_BIT   = 20;
  localparam int unsigned CAP_BIT   = 24;
  localparam int unsigned OVF_BIT   = 28;
  localparam int unsigned VLD_BIT   = 24;
  localparam int unsigned THR_RESET = 7;
endpackage

// File: rtl/tsu_edge_sync.sv
`timescale 1ns/1ps
module tsu_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q, sh_d;
  logic            lvl, lvl_prev;

  assign sh_d     = {sh_q[STAGES-1:0], pin_i};
  assign lvl      = sh_q[STAGES-1];
  assign lvl_prev = sh_q[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    if (fall_sel_i) edge_o = ~lvl & lvl_prev;
    else            edge_o = lvl & ~lvl_prev;
  end

  // R1: a detected edge lasts one cycle unless the polarity was flipped
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (!edge_o || (fall_sel_i != $past(fall_sel_i))));
endmodule

// File: rtl/tsu_stamp_fifo.sv
`timescale 1ns/1ps
module tsu_stamp_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_i,
  input  logic [CW-1:0] thr_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o,
  output logic          thr_hit_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          rd_ok, wr_ok, empty, full;

  assign empty = (count_q == '0);
  assign full  = (count_q == CW'(DEPTH));

  always_comb begin
    rd_ok     = rd_i & ~empty;
    wr_ok     = wr_i & (~full | rd_ok);
    ovf_o     = wr_i & ~wr_ok;
    count_d   = count_q + CW'(wr_ok) - CW'(rd_ok);
    thr_hit_o = wr_ok & (count_q < thr_i) & (count_d >= thr_i);
    wr_ptr_d  = wr_ptr_q;
    rd_ptr_d  = rd_ptr_q;
    if (wr_ok) wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
    if (rd_ok) rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign head_o  = empty ? '0 : mem_q[rd_ptr_q];
  assign count_o = count_q;

  // R7: a write into a full FIFO without a pop leaves it full and untouched
  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_i && !rd_i) |=> (count_q == CW'(DEPTH) && $stable(wr_ptr_q) && $stable(rd_ptr_q)));
  // R5: a pop alone lowers the fill by one
  a_r5_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !empty && !wr_i) |=> (count_q == $past(count_q) - CW'(1)));
  // R4: an accepted write leaves the FIFO non-empty
  a_r4_nonempty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (count_q != '0));
  // R6: a read of an empty FIFO moves nothing
  a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && empty && !wr_i) |=> (count_q == '0 && $stable(rd_ptr_q)));
endmodule

// File: rtl/trig_stamp_unit.sv
`timescale 1ns/1ps
module trig_stamp_unit
  import tsu_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TS_W       = 64,
  localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] time_cnt,
  input  logic [NCH-1:0]  trig_in,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [NCH-1:0]  pol_q, pol_d;
  logic [31:0]     en_q, en_d, flag_q, flag_d, evt_set, evt_mask;
  logic [CW-1:0]   thr_q, thr_d;
  logic [NCH-1:0]  cap_e, ovf_e, thr_e, pop, nonempty;
  logic [TS_W-1:0] head [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [7:0] LO_A = OFS_STAMP0 + 8'(CH_STRIDE * c);
    localparam logic [7:0] HI_A = LO_A + 8'd4;
    logic [CW-1:0] cnt;

    assign pop[c] = reg_rd && (reg_addr == HI_A);

    tsu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_int_n), .pin_i(trig_in[c]),
      .fall_sel_i(pol_q[c]), .edge_o(cap_e[c])
    );

    tsu_stamp_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_int_n), .wr_i(cap_e[c]), .wdata_i(time_cnt),
      .rd_i(pop[c]), .thr_i(thr_q), .head_o(head[c]), .count_o(cnt),
      .ovf_o(ovf_e[c]), .thr_hit_o(thr_e[c])
    );

    assign nonempty[c] = (cnt != '0);
  end

  // event set vector and valid-bit mask
  always_comb begin
    evt_set  = '0;
    evt_mask = '0;
    for (int c = 0; c < NCH; c++) begin
      evt_set[CAP_BIT + c]  = cap_e[c];
      evt_set[THR_BIT + c]  = thr_e[c];
      evt_set[OVF_BIT + c]  = ovf_e[c];
      evt_mask[CAP_BIT + c] = 1'b1;
      evt_mask[THR_BIT + c] = 1'b1;
      evt_mask[OVF_BIT + c] = 1'b1;
    end
  end

  // register next state; a new event wins over a clear in the same cycle
  always_comb begin
    pol_d  = pol_q;
    en_d   = en_q;
    thr_d  = thr_q;
    flag_d = flag_q;
    if (reg_wr) begin
      case (reg_addr)
        OFS_CTRL: pol_d  = reg_wdata[POL_BIT +: NCH];
        OFS_EN:   en_d   = reg_wdata & evt_mask;
        OFS_THR:  thr_d  = reg_wdata[CW-1:0];
        OFS_FLAG: flag_d = flag_q & ~reg_wdata;
        default: ;
      endcase
    end
    flag_d = flag_d | evt_set;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pol_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
      thr_q  <= CW'(THR_RESET);
    end else begin
      pol_q  <= pol_d;
      en_q   <= en_d;
      flag_q <= flag_d;
      thr_q  <= thr_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL: reg_rdata[POL_BIT +: NCH] = pol_q;
        OFS_FLAG: reg_rdata = flag_q;
        OFS_EN:   reg_rdata = en_q;
        OFS_STAT: reg_rdata[VLD_BIT +: NCH] = nonempty;
        OFS_THR:  reg_rdata[CW-1:0] = thr_q;
        default: begin
          for (int c = 0; c < NCH; c++) begin
            if (reg_addr == OFS_STAMP0 + 8'(CH_STRIDE * c))
              reg_rdata = head[c][31:0];
            if (reg_addr == OFS_STAMP0 + 8'(CH_STRIDE * c) + 8'd4)
              reg_rdata = head[c][TS_W-1:32];
          end
        end
      endcase
    end
  end

  assign irq = |(flag_q & en_q);

  // R9, R10: an enabled capture event raises irq on the next cycle
  a_r10_irq_on_capture: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cap_e[0] && en_q[CAP_BIT] && !(reg_wr && reg_addr == OFS_EN)) |=> irq);
  // R7: a dropped capture leaves its overflow flag set
  a_r7_ovf_flag: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovf_e[0] |=> flag_q[OVF_BIT]);
  // R10: with all enables clear, irq stays low
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_q == '0) |-> !irq);
endmodule

// File: tb/tb_trig_stamp_unit.sv
`timescale 1ns/1ps
module tb_trig_stamp_unit;
  localparam logic [7:0] A_CTRL = 8'h00, A_FLAG = 8'h04, A_EN = 8'h08,
                         A_STAT = 8'h0C, A_THR = 8'h10;
  // {channel, falling, base}
  localparam logic [65:0] VEC [6] = '{
    {1'b0, 1'b0, 64'h0000_0012_3456_7000},
    {1'b1, 1'b0, 64'h0000_0ABC_0000_1000},
    {1'b0, 1'b1, 64'h0000_0005_FFFF_FFFE},
    {1'b1, 1'b1, 64'hFEDC_BA98_7654_3210},
    {1'b1, 1'b0, 64'h0000_0000_0000_0001},
    {1'b0, 1'b0, 64'h8000_0000_0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] tc;
  logic [1:0]  trig;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  trig_stamp_unit dut (
    .clk(clk), .rst_n(rst_n), .time_cnt(tc), .trig_in(trig),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  // idle at pol, then go to the active level; tc steps every cycle
  task automatic pulse(input int ch, input logic pol, input logic [63:0] base);
    trig[ch] = pol;
    repeat (5) @(negedge clk);
    trig[ch] = ~pol; tc = base;
    @(negedge clk); tc = base + 64'd1;
    @(negedge clk); tc = base + 64'd2;
    @(negedge clk); tc = base + 64'd3;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, d2;
    logic [63:0] exp;
    rst_n = 1'b0; trig = '0; tc = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(A_CTRL, d); chk("R11 ctrl reset", 64'(d), 64'h0);
    rd(A_THR, d);  chk("R8 threshold reset", 64'(d), 64'd7);
    rd(A_STAT, d); chk("R4 status reset", 64'(d), 64'h0);
    rd(A_FLAG, d); chk("R10 flags reset", 64'(d), 64'h0);
    chk("R10 irq reset", 64'(irq), 64'h0);

    // table of captures
    for (int i = 0; i < 6; i++) begin
      int ch;
      logic pol;
      logic [7:0] lo_a;
      ch   = int'(VEC[i][65]);
      pol  = VEC[i][64];
      lo_a = 8'h20 + 8'(8 * ch);
      wr(A_CTRL, 32'(pol) << (8 + ch));
      rd(A_CTRL, d); chk("R11 ctrl readback", 64'(d), 64'(32'(pol) << (8 + ch)));
      pulse(ch, pol, VEC[i][63:0]);
      exp = VEC[i][63:0] + 64'd2;
      rd(A_STAT, d); chk("R4 R2 one entry only", 64'(d), 64'(32'h1 << (24 + ch)));
      rd(lo_a, d);         chk("R1 R2 low word", 64'(d), 64'(exp[31:0]));
      rd(lo_a + 8'd4, d);  chk("R1 R5 high word", 64'(d), 64'(exp[63:32]));
      rd(A_STAT, d); chk("R4 drained", 64'(d), 64'h0);
    end

    // R10 write-one-to-clear of capture flags
    rd(A_FLAG, d); chk("R9 capture flags", 64'(d), 64'h0300_0000);
    wr(A_FLAG, 32'h0100_0000);
    rd(A_FLAG, d); chk("R10 partial clear", 64'(d), 64'h0200_0000);
    wr(A_FLAG, 32'hFFFF_FFFF);
    rd(A_FLAG, d); chk("R10 full clear", 64'(d), 64'h0);

    // fill channel 1 past its depth, rising edge, default threshold 7
    wr(A_CTRL, 32'h0);
    for (int k = 0; k < 17; k++) begin
      pulse(1, 1'b0, 64'h0000_A000_0000_0000 + 64'(k * 256));
      if (k == 5) begin
        rd(A_FLAG, d); chk("R8 no threshold at 6", 64'(d[21]), 64'h0);
      end
      if (k == 6) begin
        rd(A_FLAG, d); chk("R8 threshold at 7", 64'(d[21]), 64'h1);
      end
      if (k == 15) begin
        rd(A_FLAG, d); chk("R7 no overflow at 16", 64'(d[29]), 64'h0);
      end
    end
    rd(A_FLAG, d); chk("R7 R9 flags after overflow", 64'(d), 64'h2220_0000);
    rd(A_STAT, d); chk("R3 R4 only channel 1 valid", 64'(d), 64'h0200_0000);
    rd(8'h28, d);  rd(8'h28, d2);
    chk("R5 low read does not pop", 64'(d2), 64'(d));
    for (int k = 0; k < 16; k++) begin
      exp = 64'h0000_A000_0000_0000 + 64'(k * 256) + 64'd2;
      rd(8'h28, d); rd(8'h2C, d2);
      chk("R3 R7 order after overflow", {d2, d}, exp);
    end
    rd(A_STAT, d); chk("R7 extra capture dropped", 64'(d), 64'h0);
    rd(8'h2C, d);  chk("R6 empty high read", 64'(d), 64'h0);
    rd(8'h28, d);  chk("R6 empty low read", 64'(d), 64'h0);
    rd(A_STAT, d); chk("R6 state unchanged", 64'(d), 64'h0);

    // interrupt masking
    chk("R10 irq masked", 64'(irq), 64'h0);
    wr(A_EN, 32'h2000_0000);
    #2 chk("R10 irq enabled", 64'(irq), 64'h1);
    wr(A_FLAG, 32'h2000_0000);
    #2 chk("R10 irq after clear", 64'(irq), 64'h0);
    wr(A_FLAG, 32'hFFFF_FFFF);

    // reprogrammed threshold on channel 0
    wr(A_THR, 32'd2);
    rd(A_THR, d); chk("R8 threshold readback", 64'(d), 64'd2);
    pulse(0, 1'b0, 64'h55);
    rd(A_FLAG, d); chk("R8 below new threshold", 64'(d[20]), 64'h0);
    pulse(0, 1'b0, 64'h77);
    rd(A_FLAG, d); chk("R8 new threshold reached", 64'(d[20]), 64'h1);
    rd(8'h24, d); rd(8'h20, d);
    chk("R3 second entry", 64'(d), 64'h79);

    finish_run();
  end
endmodule